// File: doc/BRIEF.md
# Three-Code I2C Slave Front End

This block is the bus-facing half of a slave that answers on a two-wire serial bus (I2C/SMBus style) under three device-type codes at once. All three codes share one 3-bit pin-strapped sub-address. The block watches the already synchronised SCL and SDA lines and detects START, repeated START and STOP. It shifts in the address byte and routes the transfer to one of three targets: a byte-wide serial memory, a write-protect command unit, or a 16-bit sensor register file. It only ever pulls SDA low and has no SCL output, so it can never stretch the clock.

Memory traffic is passed one byte at a time through strobes. A write-protect access is reported as a single command strobe when its address byte is acknowledged. The sensor file is reached through an internal pointer. The first data byte of a sensor write loads that pointer, and later bytes arrive in high/low pairs that form one 16-bit word. A sensor read returns the addressed word high byte first. The pointer survives a repeated START and a STOP, so a pointer write followed by a read works in one transfer or in two.

Top module: `i2c_tri_slave`

## Requirements
- R1: The slave acknowledges an address byte only when bits 3..1 equal `strap` and bits 7..4 hold one of its three codes. Otherwise it leaves SDA released for the rest of that byte and for all further bytes, and raises no strobe, until the next START.
- R2: Code 4'b1010 routes to the memory target, 4'b0011 to the sensor target, and 4'b0110 to the write-protect target. The write-protect target gets one `wpCmdStb` pulse when its address is acknowledged, with `wpCmdRnw` equal to address bit 0. A read from it returns `wpRdata`, and data bytes written to it are acknowledged and dropped.
- R3: After every 8-bit byte of a matched write, the slave holds SDA low through the 9th clock.
- R4: Bytes are received MSB first. For a memory write, the complete byte appears on `busWdata` together with a one-cycle `memWrStb` after the 8th bit.
- R5: In a sensor write, the first data byte loads `snsPtr`. Each following pair of bytes (high, then low) raises one `snsWrStb` with `snsWdata` = {high, low}.
- R6: A sensor read sends the high byte of `snsRdata`, then the low byte, MSB first. While the master keeps acknowledging, the same high/low sequence repeats.
- R7: A repeated START restarts address decoding. `snsPtr` keeps its value across repeated START and STOP.
- R8: When the master answers a read byte with NoAck, the slave releases SDA and sends nothing more until the next START.
- R9: After reset or STOP the slave is idle with SDA released, and a STOP part-way through a byte discards the partial byte.
- R10: Each memory read byte is the value of `memRdata` in the cycle of a one-cycle `memRdStb` pulse, taken as the byte is loaded for sending.
- R11: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised SCL line level |
| sdaIn | input | 1 | Synchronised SDA line level (wired-AND bus) |
| strap | input | 3 | Pin-strapped sub-address |
| sdaOe | output | 1 | 1 = pull SDA low |
| memWrStb | output | 1 | Memory byte write strobe |
| memRdStb | output | 1 | Memory byte fetch strobe |
| busWdata | output | 8 | Received data byte |
| memRdata | input | 8 | Memory byte to send |
| wpCmdStb | output | 1 | Write-protect command strobe |
| wpCmdRnw | output | 1 | Read/write bit of the write-protect command |
| wpRdata | input | 8 | Write-protect status byte to send |
| snsPtr | output | 8 | Sensor register pointer |
| snsWrStb | output | 1 | Sensor word write strobe |
| snsWdata | output | 16 | Sensor word to write |
| snsRdata | input | 16 | Sensor word at `snsPtr` |

## Verification
A corrupted bit counter or state register shows up on the bus within one byte time. It appears as a missing or misplaced acknowledge pulse, or as a read byte shifted by one bit. A wrong target or pointer register shows up at the next data strobe, as a word delivered to the wrong port or with the wrong pointer, or as a read returning another register's word. A stuck high/low phase flag shows up on the second byte of a sensor read, which repeats the high byte instead of sending the low one.

// File: rtl/i2c_tri_pkg.sv
package i2c_tri_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } busState_e;

  typedef enum logic [1:0] {
    TGT_MEM, TGT_WP, TGT_SNS, TGT_NONE
  } target_e;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic latchAddr;
    logic dataWr;
    logic loadTx;
  } ctrlStb_t;
endpackage

// File: rtl/i2c_tri_ctrl.sv
module i2c_tri_ctrl
  import i2c_tri_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  logic     addrMatch,
  input  logic     rnw,
  input  logic     txBit,
  output ctrlStb_t stb,
  output logic     sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  busState_e state;
  logic [CNT_W-1:0] bitCnt;
  logic sclQ, sdaQ, isAddr, mAck;
  logic sclRise, sclFall, startDet, stopDet;

  assign sclRise  = sclIn & ~sclQ;
  assign sclFall  = ~sclIn & sclQ;
  assign startDet = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopDet  = sclIn & sclQ & ~sdaQ & sdaIn;

  assign sdaOe = (state == ST_ACK) | ((state == ST_TX) & ~txBit);

  always_comb begin
    stb = '0;
    unique case (state)
      ST_RX: begin
        stb.shiftIn = sclRise && (bitCnt != FULL);
        if (sclFall && bitCnt == FULL) begin
          stb.latchAddr = isAddr && addrMatch;
          stb.dataWr    = !isAddr;
        end
      end
      ST_ACK:  stb.loadTx   = sclFall && rnw;
      ST_TX:   stb.shiftOut = sclFall && (bitCnt != LAST);
      ST_MACK: stb.loadTx   = sclFall && mAck;
      default: ;
    endcase
    if (startDet || stopDet) stb = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; sclQ <= 1'b1; sdaQ <= 1'b1;
      isAddr <= 1'b0; mAck <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startDet) begin
        state <= ST_RX; bitCnt <= '0; isAddr <= 1'b1;
      end else if (stopDet) begin
        state <= ST_IDLE; bitCnt <= '0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (sclRise && bitCnt != FULL) bitCnt <= bitCnt + 1'b1;
            if (sclFall && bitCnt == FULL) begin
              state  <= (isAddr && !addrMatch) ? ST_IDLE : ST_ACK;
              isAddr <= 1'b0;
            end
          end
          ST_ACK: if (sclFall) begin
            bitCnt <= '0;
            state  <= rnw ? ST_TX : ST_RX;
          end
          ST_TX: if (sclFall) begin
            if (bitCnt == LAST) state <= ST_MACK;
            else bitCnt <= bitCnt + 1'b1;
          end
          ST_MACK: begin
            if (sclRise) mAck <= ~sdaIn;
            if (sclFall) begin
              bitCnt <= '0;
              state  <= mAck ? ST_TX : ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: a new SDA pull may only begin while SCL is low
  a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);
  // R1: a mismatched address leaves the slave idle and SDA released
  a_r1_nomatch_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX && isAddr && sclFall && bitCnt == FULL && !addrMatch && !startDet && !stopDet)
      |=> (state == ST_IDLE && !sdaOe));
  // R9: STOP returns to idle with SDA released
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaOe));
  // R8: master NoAck releases SDA
  a_r8_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MACK && sclFall && !mAck && !startDet && !stopDet) |=> !sdaOe);
endmodule

// File: rtl/i2c_tri_dp.sv
module i2c_tri_dp
  import i2c_tri_pkg::*;
#(
  parameter logic [3:0] MEM_CODE = 4'b1010,
  parameter logic [3:0] WP_CODE  = 4'b0110,
  parameter logic [3:0] SNS_CODE = 4'b0011,
  parameter int STRAP_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            stb,
  input  logic                sdaIn,
  input  logic [STRAP_W-1:0]  strap,
  output logic                addrMatch,
  output logic                rnw,
  output logic                txBit,
  output logic                memWrStb,
  output logic                memRdStb,
  output logic [BYTE_W-1:0]   busWdata,
  input  logic [BYTE_W-1:0]   memRdata,
  output logic                wpCmdStb,
  output logic                wpCmdRnw,
  input  logic [BYTE_W-1:0]   wpRdata,
  output logic [BYTE_W-1:0]   snsPtr,
  output logic                snsWrStb,
  output logic [2*BYTE_W-1:0] snsWdata,
  input  logic [2*BYTE_W-1:0] snsRdata
);
  localparam int CODE_W = BYTE_W - 1 - STRAP_W;

  logic [BYTE_W-1:0] sr, hold, ptr, txByte;
  target_e tgt, decTgt;
  logic firstData, hiPend, rdLo;
  logic [CODE_W-1:0] codeF;

  assign codeF = sr[BYTE_W-1 -: CODE_W];

  always_comb begin
    if (codeF == MEM_CODE)      decTgt = TGT_MEM;
    else if (codeF == WP_CODE)  decTgt = TGT_WP;
    else if (codeF == SNS_CODE) decTgt = TGT_SNS;
    else                        decTgt = TGT_NONE;
  end

  assign addrMatch = (sr[STRAP_W:1] == strap) && (decTgt != TGT_NONE);

  always_comb begin
    unique case (tgt)
      TGT_MEM: txByte = memRdata;
      TGT_WP:  txByte = wpRdata;
      TGT_SNS: txByte = rdLo ? snsRdata[BYTE_W-1:0] : snsRdata[2*BYTE_W-1:BYTE_W];
      default: txByte = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sr <= '0; hold <= '0; ptr <= '0; tgt <= TGT_NONE; rnw <= 1'b0;
      firstData <= 1'b0; hiPend <= 1'b0; rdLo <= 1'b0;
    end else begin
      if (stb.shiftIn)  sr <= {sr[BYTE_W-2:0], sdaIn};
      if (stb.shiftOut) sr <= {sr[BYTE_W-2:0], 1'b1};
      if (stb.loadTx) begin
        sr <= txByte;
        if (tgt == TGT_SNS) rdLo <= ~rdLo;
      end
      if (stb.latchAddr) begin
        tgt <= decTgt; rnw <= sr[0];
        firstData <= 1'b1; hiPend <= 1'b0; rdLo <= 1'b0;
      end
      if (stb.dataWr) begin
        firstData <= 1'b0;
        if (tgt == TGT_SNS) begin
          if (firstData)    ptr <= sr;
          else if (!hiPend) begin hold <= sr; hiPend <= 1'b1; end
          else              hiPend <= 1'b0;
        end
      end
    end
  end

  assign txBit    = sr[BYTE_W-1];
  assign busWdata = sr;
  assign memWrStb = stb.dataWr && tgt == TGT_MEM;
  assign memRdStb = stb.loadTx && tgt == TGT_MEM;
  assign wpCmdStb = stb.latchAddr && decTgt == TGT_WP;
  assign wpCmdRnw = sr[0];
  assign snsWrStb = stb.dataWr && tgt == TGT_SNS && !firstData && hiPend;
  assign snsWdata = {hold, sr};
  assign snsPtr   = ptr;

  // R2: at most one target strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrStb, memRdStb, wpCmdStb, snsWrStb}));
  // R7: re-decoding an address never disturbs the pointer
  a_r7_ptr_kept: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchAddr |=> $stable(ptr));
  // R5: a sensor word write closes the high/low pair
  a_r5_pair_close: assert property (@(posedge clk) disable iff (!rstN)
    snsWrStb |=> !hiPend);
endmodule

// File: rtl/i2c_tri_slave.sv
module i2c_tri_slave
  import i2c_tri_pkg::*;
#(
  parameter logic [3:0] MEM_CODE = 4'b1010,
  parameter logic [3:0] WP_CODE  = 4'b0110,
  parameter logic [3:0] SNS_CODE = 4'b0011
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  strap,
  output logic        sdaOe,
  output logic        memWrStb,
  output logic        memRdStb,
  output logic [7:0]  busWdata,
  input  logic [7:0]  memRdata,
  output logic        wpCmdStb,
  output logic        wpCmdRnw,
  input  logic [7:0]  wpRdata,
  output logic [7:0]  snsPtr,
  output logic        snsWrStb,
  output logic [15:0] snsWdata,
  input  logic [15:0] snsRdata
);
  ctrlStb_t stb;
  logic addrMatch, rnw, txBit;

  i2c_tri_ctrl uCtrl (
    .clk, .rstN, .sclIn, .sdaIn, .addrMatch, .rnw, .txBit, .stb, .sdaOe
  );

  i2c_tri_dp #(.MEM_CODE(MEM_CODE), .WP_CODE(WP_CODE), .SNS_CODE(SNS_CODE), .STRAP_W(3)) uDp (
    .clk, .rstN, .stb, .sdaIn, .strap, .addrMatch, .rnw, .txBit,
    .memWrStb, .memRdStb, .busWdata, .memRdata, .wpCmdStb, .wpCmdRnw, .wpRdata,
    .snsPtr, .snsWrStb, .snsWdata, .snsRdata
  );
endmodule

// File: tb/sim_i2c_tri_slave.sv
module sim_i2c_tri_slave;
  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, memWrStb, memRdStb, wpCmdStb, wpCmdRnw, snsWrStb;
  logic [7:0] busWdata, memRdata, snsPtr;
  logic [15:0] snsWdata, snsRdata;
  logic sdaLine;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] WP_STATUS = 8'h5A;

  int tests = 0, fails = 0, r11Bad = 0;
  logic [25:0] expQ[$];
  logic [7:0] memArr [16];
  logic [15:0] snsRegs [4];
  logic [3:0] memIdx;
  logic prevOe;

  always #10 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  i2c_tri_slave u0 (
    .clk, .rstN, .sclIn(sclM), .sdaIn(sdaLine), .strap(STRAP), .sdaOe,
    .memWrStb, .memRdStb, .busWdata, .memRdata, .wpCmdStb, .wpCmdRnw,
    .wpRdata(WP_STATUS), .snsPtr, .snsWrStb, .snsWdata, .snsRdata
  );

  // target stubs
  assign memRdata = memArr[memIdx];
  assign snsRdata = snsRegs[snsPtr[1:0]];
  always_ff @(posedge clk) begin
    if (!rstN) memIdx <= '0;
    else begin
      if (memWrStb) begin memArr[memIdx] <= busWdata; memIdx <= memIdx + 1'b1; end
      if (memRdStb) memIdx <= memIdx + 1'b1;
      if (snsWrStb) snsRegs[snsPtr[1:0]] <= snsWdata;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  // scoreboard monitor: pops an expected strobe item for each strobe seen
  always @(negedge clk) begin
    if (rstN) begin
      logic [25:0] got;
      logic any;
      any = 1'b1;
      if (memWrStb)      got = {2'd1, 16'h0, busWdata};
      else if (snsWrStb) got = {2'd2, snsPtr, snsWdata};
      else if (wpCmdStb) got = {2'd3, 23'h0, wpCmdRnw};
      else any = 1'b0;
      if (any) begin
        if (expQ.size() == 0) check(1'b0, "R1/R2 unexpected strobe", 32'(got), 0);
        else begin
          logic [25:0] e;
          e = expQ.pop_front();
          check(got == e, "R2/R4/R5 strobe item", 32'(got), 32'(e));
        end
      end
      if (sdaOe && !prevOe && sclM) r11Bad++;
    end
    prevOe = sdaOe;
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic startC(); sdaM = 1; wt(2); sclM = 1; wt(4); sdaM = 0; wt(4); sclM = 0; wt(4); endtask
  task automatic stopC(); sdaM = 0; wt(4); sclM = 1; wt(4); sdaM = 1; wt(6); endtask
  task automatic sendBit(input logic b); sdaM = b; wt(4); sclM = 1; wt(4); sclM = 0; wt(4); endtask
  task automatic recvBit(output logic b); sdaM = 1; wt(4); sclM = 1; wt(2); b = sdaLine; wt(2); sclM = 0; wt(4); endtask
  task automatic wrByte(input logic [7:0] v, output logic ack);
    logic n;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(n); ack = ~n;
  endtask
  task automatic rdByte(input logic ackIt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recvBit(v[i]);
    sendBit(~ackIt);
  endtask
  task automatic wrExpAck(input logic [7:0] v, input logic expAck, input string req);
    logic a;
    wrByte(v, a);
    check(a == expAck, req, 32'(a), 32'(expAck));
  endtask
  task automatic rdExp(input logic ackIt, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rdByte(ackIt, v);
    check(v == exp, req, 32'(v), 32'(exp));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) memArr[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 4; i++) snsRegs[i] = 16'h1000 + 16'(i) * 16'h0111;
    wt(5);
    check(sdaOe == 1'b0, "R9 reset released", 32'(sdaOe), 0);
    rstN = 1; wt(4);

    // memory write, MSB-first bytes
    startC();
    wrExpAck({4'b1010, STRAP, 1'b0}, 1, "R1 mem addr ack");
    expQ.push_back({2'd1, 16'h0, 8'hA5}); wrExpAck(8'hA5, 1, "R3 R4 ack byte1");
    expQ.push_back({2'd1, 16'h0, 8'h3C}); wrExpAck(8'h3C, 1, "R3 R4 ack byte2");
    stopC();

    // memory read from index 2
    startC();
    wrExpAck({4'b1010, STRAP, 1'b1}, 1, "R1 mem read addr");
    rdExp(1, 8'd17, "R10 mem byte0"); rdExp(1, 8'd24, "R10 mem byte1");
    rdExp(0, 8'd31, "R10 mem byte2");
    check(sdaOe == 1'b0, "R8 release after NoAck", 32'(sdaOe), 0);
    stopC();

    // wrong strap, wrong code
    startC();
    wrExpAck({4'b1010, STRAP ^ 3'b001, 1'b0}, 0, "R1 strap mismatch");
    wrExpAck(8'h55, 0, "R1 ignored after mismatch");
    stopC();
    startC(); wrExpAck({4'b0101, STRAP, 1'b0}, 0, "R1 unknown code"); stopC();

    // write-protect target
    expQ.push_back({2'd3, 23'h0, 1'b0});
    startC();
    wrExpAck({4'b0110, STRAP, 1'b0}, 1, "R2 wp addr");
    wrExpAck(8'h12, 1, "R2 wp data acked");
    stopC();
    expQ.push_back({2'd3, 23'h0, 1'b1});
    startC();
    wrExpAck({4'b0110, STRAP, 1'b1}, 1, "R2 wp read addr");
    rdExp(0, WP_STATUS, "R2 wp status");
    stopC();

    // sensor word write to pointer 1
    expQ.push_back({2'd2, 8'h01, 16'hBEEF});
    startC();
    wrExpAck({4'b0011, STRAP, 1'b0}, 1, "R2 sns addr");
    wrExpAck(8'h01, 1, "R5 pointer");
    wrExpAck(8'hBE, 1, "R5 high"); wrExpAck(8'hEF, 1, "R5 low");
    stopC();

    // pointer write then repeated START read
    startC();
    wrExpAck({4'b0011, STRAP, 1'b0}, 1, "R7 sns addr");
    wrExpAck(8'h02, 1, "R7 pointer");
    sdaM = 1; wt(2); startC();
    wrExpAck({4'b0011, STRAP, 1'b1}, 1, "R7 reread addr");
    rdExp(1, 8'h12, "R6 hi"); rdExp(1, 8'h22, "R6 lo");
    rdExp(1, 8'h12, "R6 hi repeat"); rdExp(0, 8'h22, "R6 lo repeat");
    check(sdaOe == 1'b0, "R8 release", 32'(sdaOe), 0);
    stopC();

    // pointer persists across STOP; word written earlier
    startC();
    wrExpAck({4'b0011, STRAP, 1'b0}, 1, "R7 addr"); wrExpAck(8'h01, 1, "R7 ptr1");
    stopC();
    startC();
    wrExpAck({4'b0011, STRAP, 1'b1}, 1, "R7 read after STOP");
    rdExp(1, 8'hBE, "R5 R7 readback hi"); rdExp(0, 8'hEF, "R5 R7 readback lo");
    stopC();

    // STOP in the middle of an address byte
    startC();
    sendBit(1); sendBit(0); sendBit(1); sendBit(0);
    stopC();
    check(sdaOe == 1'b0, "R9 idle after partial", 32'(sdaOe), 0);
    expQ.push_back({2'd1, 16'h0, 8'h77});
    startC();
    wrExpAck({4'b1010, STRAP, 1'b0}, 1, "R9 fresh decode");
    wrExpAck(8'h77, 1, "R9 R4 data");
    stopC();

    wt(10);
    check(expQ.size() == 0, "R2 all strobes seen", 32'(expQ.size()), 0);
    check(r11Bad == 0, "R11 pull only with SCL low", 32'(r11Bad), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule